// File: doc/BRIEF.md
# Page Translation Buffer with Hardware Table Walk

The block turns a 32-bit virtual byte address into a 32-bit physical address for 4 KiB pages. An 8-entry fully associative table keeps recently used page mappings. Each entry stores the virtual page number, the physical page number and three access rights: read, write and execute. When a request finds its page in the table, the translated address, or a fault, appears in the cycle after the request is accepted. No memory traffic takes place in that case.

When a request misses, the block stops taking requests. It reads one page-table word through a simple memory read port. A valid word is written into the table in round-robin order, and the request then completes from the fetched word. Pages that are not mapped, and accesses that the page does not allow, complete with the fault output set instead of an address. A flush input clears the whole table in one cycle.

Top module: `tlb_walker`

## Requirements
- R1: A translated address is the 20-bit physical page number of the entry, in bits 31:12, joined to the unchanged virtual address bits 11:0. A faulting response drives the address as zero.
- R2: When the page is in the table, `rsp_valid_o` is high in the cycle right after acceptance, and no page-table read is issued.
- R3: On a miss, the block holds `mem_req_o` with `mem_addr_o` = `pt_base_i` + 4 × (virtual address bits 31:12). It installs the returned word and completes the request. A later request to the same page is a hit.
- R4: A page-table word is valid only when bit 0 is 1 and bits 11:4 are zero. An invalid word gives a fault response and is not installed, so the next request to that page walks again.
- R5: Access codes are 00 = read, 01 = write and 10 = fetch. They need word bits 1, 2 and 3 respectively, which hold the R, W and X rights. A missing right, or code 11, gives a fault. Hits are checked against the stored rights in the same way.
- R6: `req_ready_o` is low while a walk is in progress. `mem_req_o` stays high until `mem_rvalid_i` is seen.
- R7: Installs fill the 8 entries in round-robin order. The ninth install replaces the oldest entry, and the other entries keep their contents.
- R8: A one-cycle pulse on `flush_i` invalidates every entry, so each following request walks.
- R9: While reset is held, `req_ready_o` is 1, and `rsp_valid_o` and `mem_req_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Invalidate all table entries |
| pt_base_i | input | 32 | Page-table base byte address |
| req_valid_i | input | 1 | Translation request valid |
| req_ready_o | output | 1 | Block can take a request |
| req_vaddr_i | input | 32 | Virtual byte address |
| req_acc_i | input | 2 | Access type: 00 read, 01 write, 10 fetch |
| rsp_valid_o | output | 1 | One-cycle response strobe |
| rsp_paddr_o | output | 32 | Physical address (zero on fault) |
| rsp_fault_o | output | 1 | Unmapped page or rights violation |
| mem_req_o | output | 1 | Page-table read request |
| mem_addr_o | output | 32 | Page-table word byte address |
| mem_rvalid_i | input | 1 | Read data valid, ends the request |
| mem_rdata_i | input | 32 | Page-table word |

## Verification
The assertions assume three things about the environment. The memory raises `mem_rvalid_i` only while `mem_req_o` is high. `flush_i` is never pulsed in the same cycle as a walk completes. `pt_base_i` is held steady while a walk is in progress.

The bench's page-table model meets these conditions. It answers each read with a fixed two-cycle latency. It flushes only between requests. It keeps the base constant, and it derives every page-table word arithmetically from the page number. The sweep covers all eight combinations of rights against all four access codes.

// File: rtl/tlbw_pkg.sv
package tlbw_pkg;
  localparam int VA_W  = 32;
  localparam int PG_W  = 12;
  localparam int VPN_W = VA_W - PG_W;
  localparam int PTE_W = 32;
  localparam int PPN_W = PTE_W - PG_W;
  localparam int PA_W  = PPN_W + PG_W;

  localparam logic [1:0] ACC_RD = 2'b00;
  localparam logic [1:0] ACC_WR = 2'b01;
  localparam logic [1:0] ACC_EX = 2'b10;

  typedef struct packed {
    logic [VPN_W-1:0] vpn;
    logic [PPN_W-1:0] ppn;
    logic             x;
    logic             w;
    logic             r;
  } ent_t;
endpackage

// File: rtl/tlbw_perm.sv
module tlbw_perm
  import tlbw_pkg::*;
(
  input  logic [1:0] acc_i,
  input  ent_t       ent_i,
  output logic       fault_o
);
  always_comb begin
    unique case (acc_i)
      ACC_RD:  fault_o = !ent_i.r;
      ACC_WR:  fault_o = !ent_i.w;
      ACC_EX:  fault_o = !ent_i.x;
      default: fault_o = 1'b1;
    endcase
  end

  always_comb begin
    if (acc_i == 2'b11) begin
      assert_resv_code_faults_R5: assert (fault_o);
    end
  end
endmodule

// File: rtl/tlbw_table.sv
module tlbw_table
  import tlbw_pkg::*;
#(
  parameter int ENTRIES = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic [VPN_W-1:0] lkp_vpn_i,
  input  logic             ins_i,
  input  ent_t             ins_ent_i,
  output logic             hit_o,
  output ent_t             hit_ent_o
);
  localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(ENTRIES - 1);

  ent_t               ent_q [ENTRIES];
  logic [ENTRIES-1:0] vld_q;
  logic [ENTRIES-1:0] hit_vec;
  logic [PTR_W-1:0]   ptr_q;
  logic               wr_en;

  assign wr_en = ins_i && !flush_i;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    assign hit_vec[g] = vld_q[g] && (ent_q[g].vpn == lkp_vpn_i);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q[g] <= 1'b0;
        ent_q[g] <= '0;
      end else if (flush_i) begin
        vld_q[g] <= 1'b0;
      end else if (wr_en && ptr_q == PTR_W'(g)) begin
        vld_q[g] <= 1'b1;
        ent_q[g] <= ins_ent_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ptr_q <= '0;
    else if (wr_en) ptr_q <= (ptr_q == PTR_LAST) ? '0 : ptr_q + 1'b1;
  end

  always_comb begin
    hit_ent_o = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (hit_vec[i]) hit_ent_o = hit_ent_o | ent_q[i];
    end
  end
  assign hit_o = |hit_vec;

  assert_single_match_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit_vec));

  assert_flush_clears_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (vld_q == '0));
endmodule

// File: rtl/tlbw_walker.sv
module tlbw_walker
  import tlbw_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [VPN_W-1:0] vpn_i,
  input  logic [PTE_W-1:0] base_i,
  input  logic             mem_rvalid_i,
  input  logic [PTE_W-1:0] mem_rdata_i,
  output logic             busy_o,
  output logic             mem_req_o,
  output logic [PTE_W-1:0] mem_addr_o,
  output logic             done_o,
  output logic             pte_ok_o,
  output ent_t             ent_o
);
  typedef enum logic {W_IDLE, W_WALK} wst_t;

  wst_t             st_q;
  logic [VPN_W-1:0] vpn_q;
  logic [PTE_W-1:0] base_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= W_IDLE;
      vpn_q  <= '0;
      base_q <= '0;
    end else begin
      unique case (st_q)
        W_IDLE: if (start_i) begin
          st_q   <= W_WALK;
          vpn_q  <= vpn_i;
          base_q <= base_i;
        end
        W_WALK: if (mem_rvalid_i) st_q <= W_IDLE;
        default: st_q <= W_IDLE;
      endcase
    end
  end

  assign busy_o     = (st_q == W_WALK);
  assign mem_req_o  = busy_o;
  assign mem_addr_o = base_q + PTE_W'({vpn_q, 2'b00});
  assign done_o     = busy_o && mem_rvalid_i;
  // valid bit set and reserved field clear
  assign pte_ok_o   = mem_rdata_i[0] && (mem_rdata_i[PG_W-1:4] == '0);

  always_comb begin
    ent_o.vpn = vpn_q;
    ent_o.ppn = mem_rdata_i[PTE_W-1:PG_W];
    ent_o.x   = mem_rdata_i[3];
    ent_o.w   = mem_rdata_i[2];
    ent_o.r   = mem_rdata_i[1];
  end

  assert_req_held_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_rvalid_i) |=> mem_req_o);

  assert_addr_stable_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_rvalid_i) |=> $stable(mem_addr_o));
endmodule

// File: rtl/tlb_walker.sv
module tlb_walker
  import tlbw_pkg::*;
#(
  parameter int ENTRIES = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            flush_i,
  input  logic [31:0]     pt_base_i,
  input  logic            req_valid_i,
  output logic            req_ready_o,
  input  logic [31:0]     req_vaddr_i,
  input  logic [1:0]      req_acc_i,
  output logic            rsp_valid_o,
  output logic [31:0]     rsp_paddr_o,
  output logic            rsp_fault_o,
  output logic            mem_req_o,
  output logic [31:0]     mem_addr_o,
  input  logic            mem_rvalid_i,
  input  logic [31:0]     mem_rdata_i
);
  logic             accept, hit, miss_start;
  logic             w_busy, w_done, w_ok;
  logic             f_hit, f_walk, w_fault;
  ent_t             hit_ent, w_ent;
  logic [VPN_W-1:0] req_vpn;
  logic [PG_W-1:0]  off_q;
  logic [1:0]       acc_q;

  assign req_vpn     = req_vaddr_i[VA_W-1:PG_W];
  assign req_ready_o = !w_busy;
  assign accept      = req_valid_i && req_ready_o;
  assign miss_start  = accept && !hit;

  tlbw_table #(.ENTRIES(ENTRIES)) u_table (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .flush_i   (flush_i),
    .lkp_vpn_i (req_vpn),
    .ins_i     (w_done && w_ok),
    .ins_ent_i (w_ent),
    .hit_o     (hit),
    .hit_ent_o (hit_ent)
  );

  tlbw_walker u_walker (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (miss_start),
    .vpn_i        (req_vpn),
    .base_i       (pt_base_i),
    .mem_rvalid_i (mem_rvalid_i),
    .mem_rdata_i  (mem_rdata_i),
    .busy_o       (w_busy),
    .mem_req_o    (mem_req_o),
    .mem_addr_o   (mem_addr_o),
    .done_o       (w_done),
    .pte_ok_o     (w_ok),
    .ent_o        (w_ent)
  );

  tlbw_perm u_perm_hit  (.acc_i(req_acc_i), .ent_i(hit_ent), .fault_o(f_hit));
  tlbw_perm u_perm_walk (.acc_i(acc_q),     .ent_i(w_ent),   .fault_o(f_walk));

  assign w_fault = !w_ok || f_walk;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      off_q <= '0;
      acc_q <= '0;
    end else if (accept) begin
      off_q <= req_vaddr_i[PG_W-1:0];
      acc_q <= req_acc_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_fault_o <= 1'b0;
      rsp_paddr_o <= '0;
    end else begin
      rsp_valid_o <= 1'b0;
      if (accept && hit) begin
        rsp_valid_o <= 1'b1;
        rsp_fault_o <= f_hit;
        rsp_paddr_o <= f_hit ? '0 : {hit_ent.ppn, req_vaddr_i[PG_W-1:0]};
      end else if (w_done) begin
        rsp_valid_o <= 1'b1;
        rsp_fault_o <= w_fault;
        rsp_paddr_o <= w_fault ? '0 : {w_ent.ppn, off_q};
      end
    end
  end

  assert_hit_next_cycle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && hit) |=> (rsp_valid_o && !mem_req_o));

  assert_no_accept_in_walk_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !req_ready_o);

  assert_miss_walks_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_start |=> (mem_req_o && !rsp_valid_o));
endmodule

// File: tb/tlb_walker_bench.sv
module tlb_walker_bench;
  localparam logic [31:0] BASE = 32'h0040_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic [1:0]  req_acc = '0;
  logic        req_ready_o, rsp_valid_o, rsp_fault_o, mem_req_o;
  logic [31:0] rsp_paddr_o, mem_addr_o;
  logic        mem_rvalid;
  logic [31:0] mem_rdata;

  int checks = 0;
  int fails = 0;
  int walks, ready_viol, lat_cnt;
  logic [31:0] last_addr;

  always #10 clk = ~clk;

  tlb_walker u_tlb_walker (
    .clk_i(clk), .rst_ni(rst_n), .flush_i(flush), .pt_base_i(BASE),
    .req_valid_i(req_valid), .req_ready_o(req_ready_o),
    .req_vaddr_i(req_vaddr), .req_acc_i(req_acc),
    .rsp_valid_o(rsp_valid_o), .rsp_paddr_o(rsp_paddr_o), .rsp_fault_o(rsp_fault_o),
    .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o),
    .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata)
  );

  // page-table word: ppn = vpn ^ const, rights = vpn[2:0], invalid when vpn[3:0] == F
  function automatic logic [31:0] pte_of(logic [19:0] vpn);
    logic v;
    v = (vpn[3:0] != 4'hF);
    return {vpn ^ 20'h5A3C1, 8'h00, vpn[2:0], v};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_rvalid <= 1'b0; mem_rdata <= '0; lat_cnt <= 0;
      walks <= 0; ready_viol <= 0; last_addr <= '0;
    end else begin
      if (mem_rvalid) begin
        mem_rvalid <= 1'b0;
        lat_cnt    <= 0;
      end else if (mem_req_o) begin
        if (lat_cnt == 0) last_addr <= mem_addr_o;
        if (lat_cnt == 2) begin
          mem_rvalid <= 1'b1;
          mem_rdata  <= pte_of(20'((mem_addr_o - BASE) >> 2));
        end
        lat_cnt <= lat_cnt + 1;
      end
      if (mem_req_o && mem_rvalid) walks <= walks + 1;
      if (mem_req_o && req_ready_o) ready_viol <= ready_viol + 1;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic xlate(input logic [31:0] va, input logic [1:0] acc,
                       input bit exp_walk, input string tag);
    logic [19:0] vpn;
    logic [31:0] p, exp_pa;
    logic        ok, exp_f;
    int          w0, rv0, n;
    vpn = va[31:12];
    p   = pte_of(vpn);
    case (acc)
      2'b00:   ok = p[1];
      2'b01:   ok = p[2];
      2'b10:   ok = p[3];
      default: ok = 1'b0;
    endcase
    exp_f  = !p[0] || !ok;
    exp_pa = exp_f ? 32'h0 : {p[31:12], va[11:0]};
    w0 = walks; rv0 = ready_viol;
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; req_acc = acc;
    while (!req_ready_o) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    n = 0;
    while (!rsp_valid_o && n < 60) begin @(negedge clk); n++; end
    chk(tag, {31'h0, rsp_valid_o}, 32'h1);
    chk(tag, {31'h0, rsp_fault_o}, {31'h0, exp_f});
    chk("R1", rsp_paddr_o, exp_pa);
    if (exp_walk) begin
      chk("R3", 32'(walks - w0), 32'h1);
      chk("R3", last_addr, BASE + {10'h0, vpn, 2'b00});
      chk("R6", 32'(ready_viol - rv0), 32'h0);
    end else begin
      chk("R2", 32'(walks - w0), 32'h0);
      chk("R2", 32'(n), 32'h0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R9", {31'h0, req_ready_o}, 32'h1);
    chk("R9", {31'h0, rsp_valid_o}, 32'h0);
    chk("R9", {31'h0, mem_req_o}, 32'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R5: all rights combinations against all access codes
    for (int v = 0; v < 8; v++) begin
      for (int a = 0; a < 4; a++) begin
        xlate({20'h12340 + 20'(v), 12'(v * 12'h1F3 + a * 12'h101)}, 2'(a), a == 0, "R5");
      end
    end

    // R4: invalid word is not installed
    xlate(32'h1234F_ABC, 2'b00, 1'b1, "R4");
    xlate(32'h1234F_123, 2'b01, 1'b1, "R4");

    // R7: ninth install replaces slot 0
    xlate(32'h55550_010, 2'b00, 1'b1, "R7");
    xlate(32'h12342_FFF, 2'b00, 1'b0, "R7");
    xlate(32'h12340_000, 2'b00, 1'b1, "R7");
    xlate(32'h12341_777, 2'b00, 1'b1, "R7");
    xlate(32'h55550_020, 2'b00, 1'b0, "R7");
    xlate(32'h12347_ACE, 2'b10, 1'b0, "R7");

    // R8: flush empties the table
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
    xlate(32'h55550_030, 2'b00, 1'b1, "R8");
    xlate(32'h12347_001, 2'b10, 1'b1, "R8");
    xlate(32'h12347_002, 2'b00, 1'b0, "R8");

    // high page, write allowed, read refused
    xlate(32'hFFFFE_FFF, 2'b01, 1'b1, "R5");
    xlate(32'hFFFFE_000, 2'b00, 1'b0, "R5");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule